// File: doc/BRIEF.md
# Multi-Master Bus Transfer Monitor

A passive observer for a shared bus used by up to sixteen masters. It watches the grant vector, the address, the size code, the read and write strobes, the wait line and the byte-wide data lines. It never drives any of them. It follows each transfer through three steps. In the arbitration step it picks the granted master. In the address step it decodes size and direction and finds the target slave. In the data step it collects one byte per beat, and a beat completes on each edge where wait is low.

The monitor gives three kinds of output:

- A bus-state code that is reported, with a one-cycle event strobe, on every phase change.
- A completed-transfer record that is valid while a one-cycle done strobe is high.
- A running count of finished data phases, plus two error pulses.

The target slave is resolved from a small table of inclusive address windows. Software or a bench loads this table through a write port.

Top module: `busmon_top`

## Requirements
- R1: While reset is held, `mon_state` is 0 (reset-start), `xfer_count` is 0 and every strobe is low. At the first clock edge after reset is released, `mon_state` becomes 1 (reset-stop) and `mon_state_evt` pulses.
- R2: When idle, the first rising edge with a non-zero `bus_gnt` sets `mon_state` to 2 (arbitration) and pulses `mon_state_evt`. Edges with a zero grant change neither output.
- R3: The master reported in `xfer_master` is the index of the lowest set bit of the grant seen at the arbitration edge.
- R4: The address, size and strobes are sampled at the edge that follows the arbitration edge. Size code 0, 1, 2 and 3 gives `xfer_bytes` of 1, 2, 4 and 8.
- R5: The direction is encoded as `xfer_dir`: 1 for read only, 2 for write only, 0 for neither. Neither strobe gives `mon_state` 3 (no-op) and a done pulse right after the address edge. A no-op has no data phase and leaves `xfer_count` unchanged.
- R6: Both strobes high gives `mon_state` 5 (address error) and a one-cycle `err_rw_conflict`. There is no data phase, no done pulse and no count change.
- R7: A read or write gives `mon_state` 4 (address) after the address edge, and `mon_state` 6 (data) from the first data-phase edge. The data phase has `xfer_bytes` beats. A beat completes on an edge with `bus_wait` low, and the byte captured at beat k lands in `xfer_data[8k+7:8k]`. Bytes present while wait is high are ignored.
- R8: `xfer_done` is high for exactly the cycle after the final beat edge, and `xfer_count` rises by one at that same edge.
- R9: For a read or write, the address is matched against the enabled table entries, and both bounds are inclusive. The lowest matching index is reported in `xfer_slave_idx` with `xfer_slave_hit`=1. When nothing matches, `err_bad_addr` pulses for the cycle after the address edge and `xfer_slave_hit` is 0. Disabled entries never match.
- R10: With `cfg_we` high at a clock edge, entry `cfg_idx` takes `cfg_lo`, `cfg_hi` and `cfg_en`. The new window applies to every address edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 16 | Per-master grant vector |
| bus_addr | input | 16 | Bus address |
| bus_size | input | 2 | Size code |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wait | input | 1 | Beat stall |
| bus_data | input | 8 | Byte data lines |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 2 | Table entry to write |
| cfg_en | input | 1 | Entry enable value |
| cfg_lo | input | 16 | Window lower bound |
| cfg_hi | input | 16 | Window upper bound |
| mon_state | output | 4 | Bus-state code |
| mon_state_evt | output | 1 | Pulses when a state is reported |
| xfer_done | output | 1 | Record valid strobe |
| xfer_master | output | 4 | Granted master index |
| xfer_addr | output | 16 | Transfer address |
| xfer_dir | output | 2 | Direction code |
| xfer_bytes | output | 4 | Byte count |
| xfer_data | output | 64 | Packed captured bytes |
| xfer_slave_hit | output | 1 | A window matched |
| xfer_slave_idx | output | 2 | Matching entry |
| xfer_count | output | 16 | Finished data phases |
| err_rw_conflict | output | 1 | Both strobes seen |
| err_bad_addr | output | 1 | No window matched |

## Verification
Random transfers vary the grant pattern, size code, strobe pair, address class and wait stretching. Each of these checks a different part of the monitor:

- The random grant patterns separate a lowest-bit encoder from one that picks the highest bit.
- Random waits with junk bytes on the data lines show whether capture really follows wait.
- All four size codes exercise the beat-count termination.

Directed cases use the single-address window, the exact lower and upper bounds, overlapping windows, and a disabled catch-all entry. They separate inclusive from exclusive compares and first-match from last-match lookup. Runs of zero-grant cycles, no-op and conflicting strobes confirm that no spurious state, done or count change appears.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

    typedef enum logic [3:0] {
        ST_RST_START = 4'd0,
        ST_RST_STOP  = 4'd1,
        ST_ARB       = 4'd2,
        ST_NOP       = 4'd3,
        ST_ADDR      = 4'd4,
        ST_ADDR_ERR  = 4'd5,
        ST_DATA      = 4'd6
    } mon_state_e;

    typedef enum logic [1:0] {
        DIR_NOP = 2'd0,
        DIR_RD  = 2'd1,
        DIR_WR  = 2'd2
    } xfer_dir_e;

    typedef enum logic [1:0] {
        PH_RSTOP = 2'd0,
        PH_IDLE  = 2'd1,
        PH_ADDR  = 2'd2,
        PH_DATA  = 2'd3
    } phase_e;

endpackage

// File: rtl/busmon_grant_enc.sv
module busmon_grant_enc #(
    parameter int N_MASTERS = 16,
    localparam int MID_W = $clog2(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] gnt,
    output logic                 any,
    output logic [MID_W-1:0]     idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_MASTERS - 1; i >= 0; i--) begin
            if (gnt[i]) begin
                any = 1'b1;
                idx = MID_W'(i);
            end
        end
    end

    // R3: reported index is a set bit with no set bit below it
    always_comb begin
        if (any) begin
            assert_lowest_grant_R3: assert (gnt[idx] &&
                ((gnt & ((N_MASTERS'(1) << idx) - N_MASTERS'(1))) == '0));
        end
    end

endmodule

// File: rtl/busmon_range_table.sv
module busmon_range_table #(
    parameter int N_SLV  = 4,
    parameter int ADDR_W = 16,
    localparam int SID_W = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SID_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] cfg_hi,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [SID_W-1:0]  hit_idx
);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } win_t;

    win_t [N_SLV-1:0] tab_d, tab_q;
    logic [N_SLV-1:0] match;

    always_comb begin
        tab_d = tab_q;
        if (cfg_we) begin
            tab_d[cfg_idx].en = cfg_en;
            tab_d[cfg_idx].lo = cfg_lo;
            tab_d[cfg_idx].hi = cfg_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    for (genvar g = 0; g < N_SLV; g++) begin : g_cmp
        assign match[g] = tab_q[g].en &&
                          (look_addr >= tab_q[g].lo) &&
                          (look_addr <= tab_q[g].hi);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_SLV - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = SID_W'(i);
            end
        end
    end

    // R9: a reported hit lies inside an enabled window
    always_comb begin
        if (hit) begin
            assert_hit_in_window_R9: assert (tab_q[hit_idx].en &&
                look_addr >= tab_q[hit_idx].lo && look_addr <= tab_q[hit_idx].hi);
        end
    end

endmodule

// File: rtl/busmon_top.sv
module busmon_top
    import busmon_pkg::*;
#(
    parameter int N_MASTERS = 16,
    parameter int ADDR_W    = 16,
    parameter int BEAT_W    = 8,
    parameter int N_SLV     = 4,
    parameter int CNT_W     = 16,
    localparam int MID_W    = $clog2(N_MASTERS),
    localparam int SID_W    = (N_SLV > 1) ? $clog2(N_SLV) : 1,
    localparam int MAX_B    = 8,
    localparam int BYTES_W  = $clog2(MAX_B) + 1,
    localparam int BEATI_W  = $clog2(MAX_B),
    localparam int DOUT_W   = MAX_B * BEAT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] bus_gnt,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic                 bus_wait,
    input  logic [BEAT_W-1:0]    bus_data,
    input  logic                 cfg_we,
    input  logic [SID_W-1:0]     cfg_idx,
    input  logic                 cfg_en,
    input  logic [ADDR_W-1:0]    cfg_lo,
    input  logic [ADDR_W-1:0]    cfg_hi,
    output logic [3:0]           mon_state,
    output logic                 mon_state_evt,
    output logic                 xfer_done,
    output logic [MID_W-1:0]     xfer_master,
    output logic [ADDR_W-1:0]    xfer_addr,
    output logic [1:0]           xfer_dir,
    output logic [BYTES_W-1:0]   xfer_bytes,
    output logic [DOUT_W-1:0]    xfer_data,
    output logic                 xfer_slave_hit,
    output logic [SID_W-1:0]     xfer_slave_idx,
    output logic [CNT_W-1:0]     xfer_count,
    output logic                 err_rw_conflict,
    output logic                 err_bad_addr
);

    typedef struct packed {
        phase_e               phase;
        mon_state_e           code;
        logic                 evt;
        logic [MID_W-1:0]     master;
        logic [ADDR_W-1:0]    addr;
        logic [BYTES_W-1:0]   bytes;
        xfer_dir_e            dir;
        logic [BEATI_W-1:0]   beat;
        logic [DOUT_W-1:0]    data;
        logic                 hit;
        logic [SID_W-1:0]     sidx;
        logic                 done;
        logic                 err_rw;
        logic                 err_addr;
        logic [CNT_W-1:0]     count;
    } mon_t;

    mon_t r_d, r_q;

    logic             gnt_any;
    logic [MID_W-1:0] gnt_idx;
    logic             lk_hit;
    logic [SID_W-1:0] lk_idx;

    busmon_grant_enc #(.N_MASTERS(N_MASTERS)) u_genc (
        .gnt (bus_gnt),
        .any (gnt_any),
        .idx (gnt_idx)
    );

    busmon_range_table #(.N_SLV(N_SLV), .ADDR_W(ADDR_W)) u_rtab (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_en    (cfg_en),
        .cfg_lo    (cfg_lo),
        .cfg_hi    (cfg_hi),
        .look_addr (bus_addr),
        .hit       (lk_hit),
        .hit_idx   (lk_idx)
    );

    always_comb begin
        r_d          = r_q;
        r_d.evt      = 1'b0;
        r_d.done     = 1'b0;
        r_d.err_rw   = 1'b0;
        r_d.err_addr = 1'b0;
        unique case (r_q.phase)
            PH_RSTOP: begin
                r_d.code  = ST_RST_STOP;
                r_d.evt   = 1'b1;
                r_d.phase = PH_IDLE;
            end
            PH_IDLE: begin
                if (gnt_any) begin
                    r_d.code   = ST_ARB;
                    r_d.evt    = 1'b1;
                    r_d.master = gnt_idx;
                    r_d.phase  = PH_ADDR;
                end
            end
            PH_ADDR: begin
                r_d.addr  = bus_addr;
                r_d.bytes = BYTES_W'(1) << bus_size;
                r_d.beat  = '0;
                r_d.data  = '0;
                r_d.hit   = 1'b0;
                r_d.sidx  = '0;
                r_d.evt   = 1'b1;
                unique case ({bus_rd, bus_wr})
                    2'b00: begin
                        r_d.dir   = DIR_NOP;
                        r_d.code  = ST_NOP;
                        r_d.done  = 1'b1;
                        r_d.phase = PH_IDLE;
                    end
                    2'b11: begin
                        r_d.dir    = DIR_NOP;
                        r_d.code   = ST_ADDR_ERR;
                        r_d.err_rw = 1'b1;
                        r_d.phase  = PH_IDLE;
                    end
                    default: begin
                        r_d.dir      = bus_rd ? DIR_RD : DIR_WR;
                        r_d.code     = ST_ADDR;
                        r_d.hit      = lk_hit;
                        r_d.sidx     = lk_idx;
                        r_d.err_addr = !lk_hit;
                        r_d.phase    = PH_DATA;
                    end
                endcase
            end
            PH_DATA: begin
                if (r_q.code != ST_DATA) begin
                    r_d.code = ST_DATA;
                    r_d.evt  = 1'b1;
                end
                if (!bus_wait) begin
                    r_d.data[int'(r_q.beat) * BEAT_W +: BEAT_W] = bus_data;
                    if ({1'b0, r_q.beat} == r_q.bytes - 1'b1) begin
                        r_d.done  = 1'b1;
                        r_d.count = r_q.count + 1'b1;
                        r_d.phase = PH_IDLE;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                    end
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.code  <= ST_RST_START;
            r_q.phase <= PH_RSTOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign mon_state       = r_q.code;
    assign mon_state_evt   = r_q.evt;
    assign xfer_done       = r_q.done;
    assign xfer_master     = r_q.master;
    assign xfer_addr       = r_q.addr;
    assign xfer_dir        = r_q.dir;
    assign xfer_bytes      = r_q.bytes;
    assign xfer_data       = r_q.data;
    assign xfer_slave_hit  = r_q.hit;
    assign xfer_slave_idx  = r_q.sidx;
    assign xfer_count      = r_q.count;
    assign err_rw_conflict = r_q.err_rw;
    assign err_bad_addr    = r_q.err_addr;

    // R8: done lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R8: the count only moves by one, together with done of a real transfer
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_count != $past(xfer_count)) |->
            (xfer_done && xfer_dir != DIR_NOP && xfer_count == $past(xfer_count) + 1'b1));

    // R6: the conflict pulse comes with the error state and no done
    assert_conflict_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_rw_conflict |-> (mon_state == ST_ADDR_ERR && !xfer_done));

    // R4: a finished record always carries a power-of-two byte count
    assert_bytes_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> ($countones(xfer_bytes) == 1));

    // R9: an illegal-address pulse never comes with a slave hit
    assert_bad_addr_nohit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_bad_addr |-> (!xfer_slave_hit && mon_state == ST_ADDR));

    // R2: arbitration is only reported after idle states
    assert_arb_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_state_evt && mon_state == ST_ARB) |->
            ($past(mon_state) != ST_ARB && $past(mon_state) != ST_ADDR));

endmodule

// File: tb/busmon_top_bench.sv
`timescale 1ns/1ps
module busmon_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_gnt = '0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wait = 1'b0;
    logic [7:0]  bus_data = '0;
    logic        cfg_we = 1'b0, cfg_en = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_lo = '0, cfg_hi = '0;
    logic [3:0]  mon_state;
    logic        mon_state_evt, xfer_done, xfer_slave_hit, err_rw_conflict, err_bad_addr;
    logic [3:0]  xfer_master, xfer_bytes;
    logic [15:0] xfer_addr, xfer_count;
    logic [1:0]  xfer_dir, xfer_slave_idx;
    logic [63:0] xfer_data;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_cnt = 0;
    logic        m_en [4];
    logic [15:0] m_lo [4];
    logic [15:0] m_hi [4];

    always #2.5 clk = ~clk;

    busmon_top u_busmon_top (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wait(bus_wait),
        .bus_data(bus_data), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .mon_state(mon_state),
        .mon_state_evt(mon_state_evt), .xfer_done(xfer_done), .xfer_master(xfer_master),
        .xfer_addr(xfer_addr), .xfer_dir(xfer_dir), .xfer_bytes(xfer_bytes),
        .xfer_data(xfer_data), .xfer_slave_hit(xfer_slave_hit),
        .xfer_slave_idx(xfer_slave_idx), .xfer_count(xfer_count),
        .err_rw_conflict(err_rw_conflict), .err_bad_addr(err_bad_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int low_bit(input logic [15:0] g);
        for (int i = 15; i >= 0; i--) if (g[i]) low_bit = i;
    endfunction

    function automatic logic [2:0] lookup(input logic [15:0] a);
        lookup = 3'b000;
        for (int i = 3; i >= 0; i--)
            if (m_en[i] && a >= m_lo[i] && a <= m_hi[i]) lookup = {1'b1, 2'(i)};
    endfunction

    task automatic cfg_write(input int i, input logic en, input logic [15:0] lo, input logic [15:0] hi);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(i); cfg_en = en; cfg_lo = lo; cfg_hi = hi;
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[i] = en; m_lo[i] = lo; m_hi[i] = hi;
    endtask

    task automatic idle_cycles(input int n);
        logic [3:0] st;
        st = mon_state;
        for (int k = 0; k < n; k++) begin
            bus_gnt = '0;
            @(negedge clk);
            check("R2 idle keeps state", {60'd0, mon_state}, {60'd0, st});
            check("R2 idle no event", {63'd0, mon_state_evt}, 64'd0);
        end
    endtask

    task automatic run_xfer(input logic [15:0] g, input logic [15:0] a, input logic [1:0] sz,
                            input logic rd, input logic wr, input int maxw);
        int          nb, mst;
        logic [2:0]  lk;
        logic [63:0] exp_data;
        logic [1:0]  dir;
        nb  = 1 << sz;
        mst = low_bit(g);
        lk  = lookup(a);
        exp_data = '0;
        dir = (rd && !wr) ? 2'd1 : ((wr && !rd) ? 2'd2 : 2'd0);
        bus_gnt = g;
        @(negedge clk);
        check("R2 arbitration state", {60'd0, mon_state}, 64'd2);
        check("R2 arbitration event", {63'd0, mon_state_evt}, 64'd1);
        bus_gnt = '0; bus_addr = a; bus_size = sz; bus_rd = rd; bus_wr = wr;
        bus_data = 8'($urandom);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 16'($urandom); bus_size = 2'($urandom);
        if (!rd && !wr) begin
            check("R5 no-op state", {60'd0, mon_state}, 64'd3);
            check("R5 no-op done", {63'd0, xfer_done}, 64'd1);
            check("R5 no-op dir", {62'd0, xfer_dir}, 64'd0);
            check("R3 master", {60'd0, xfer_master}, 64'(mst));
            check("R4 bytes", {60'd0, xfer_bytes}, 64'(nb));
            check("R5 count kept", {48'd0, xfer_count}, 64'(exp_cnt));
            return;
        end
        if (rd && wr) begin
            check("R6 conflict state", {60'd0, mon_state}, 64'd5);
            check("R6 conflict pulse", {63'd0, err_rw_conflict}, 64'd1);
            check("R6 no done", {63'd0, xfer_done}, 64'd0);
            @(negedge clk);
            check("R6 count kept", {48'd0, xfer_count}, 64'(exp_cnt));
            check("R6 pulse ends", {63'd0, err_rw_conflict}, 64'd0);
            return;
        end
        check("R7 address state", {60'd0, mon_state}, 64'd4);
        check("R9 bad address pulse", {63'd0, err_bad_addr}, {63'd0, !lk[2]});
        for (int b = 0; b < nb; b++) begin
            int nw;
            logic [7:0] v;
            nw = (maxw > 0) ? int'($urandom % (maxw + 1)) : 0;
            for (int k = 0; k < nw; k++) begin
                bus_wait = 1'b1; bus_data = 8'($urandom);
                @(negedge clk);
                if (b == 0 && k == 0) check("R7 data state", {60'd0, mon_state}, 64'd6);
                check("R7 no done while waiting", {63'd0, xfer_done}, 64'd0);
            end
            v = 8'($urandom);
            bus_wait = 1'b0; bus_data = v;
            exp_data[b*8 +: 8] = v;
            @(negedge clk);
            if (b == 0 && nw == 0) check("R7 data state", {60'd0, mon_state}, 64'd6);
            if (b < nb - 1) check("R8 no early done", {63'd0, xfer_done}, 64'd0);
        end
        bus_data = 8'($urandom);
        exp_cnt++;
        check("R8 done", {63'd0, xfer_done}, 64'd1);
        check("R8 count", {48'd0, xfer_count}, 64'(exp_cnt));
        check("R3 master", {60'd0, xfer_master}, 64'(mst));
        check("R4 address", {48'd0, xfer_addr}, {48'd0, a});
        check("R4 bytes", {60'd0, xfer_bytes}, 64'(nb));
        check("R5 dir", {62'd0, xfer_dir}, {62'd0, dir});
        check("R7 data", xfer_data, exp_data);
        check("R9 slave hit", {63'd0, xfer_slave_hit}, {63'd0, lk[2]});
        if (lk[2]) check("R9 slave index", {62'd0, xfer_slave_idx}, {62'd0, lk[1:0]});
        @(negedge clk);
        check("R8 done one cycle", {63'd0, xfer_done}, 64'd0);
    endtask

    initial begin
        #(100000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        for (int i = 0; i < 4; i++) begin m_en[i] = 1'b0; m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1 reset state", {60'd0, mon_state}, 64'd0);
        check("R1 reset count", {48'd0, xfer_count}, 64'd0);
        check("R1 reset strobes", {60'd0, mon_state_evt, xfer_done, err_rw_conflict, err_bad_addr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset-stop state", {60'd0, mon_state}, 64'd1);
        check("R1 reset-stop event", {63'd0, mon_state_evt}, 64'd1);
        idle_cycles(3);

        // R10: windows, with overlap, a single address and a disabled catch-all
        cfg_write(0, 1'b1, 16'h1000, 16'h1FFF);
        cfg_write(1, 1'b1, 16'h1800, 16'h2FFF);
        cfg_write(2, 1'b1, 16'h8000, 16'h8000);
        cfg_write(3, 1'b0, 16'h0000, 16'hFFFF);

        // Directed corners
        run_xfer(16'h8000, 16'h1000, 2'd0, 1'b1, 1'b0, 0);  // R9 lower bound, R3 top master
        run_xfer(16'hFFFF, 16'h1FFF, 2'd1, 1'b0, 1'b1, 1);  // R9 upper bound, overlap first wins
        run_xfer(16'h0A00, 16'h2FFF, 2'd3, 1'b1, 1'b0, 2);  // R9 entry 1 upper bound
        run_xfer(16'h0001, 16'h8000, 2'd2, 1'b0, 1'b1, 0);  // R9 single-address window
        run_xfer(16'h0010, 16'h7FFF, 2'd0, 1'b1, 1'b0, 0);  // R9 miss, disabled entry ignored
        run_xfer(16'h0100, 16'h8001, 2'd1, 1'b0, 1'b1, 0);  // R9 miss just above
        run_xfer(16'h4000, 16'h1234, 2'd2, 1'b0, 1'b0, 0);  // R5 no-op
        run_xfer(16'h0006, 16'h1234, 2'd1, 1'b1, 1'b1, 0);  // R6 conflict
        idle_cycles(2);

        // R10: enable entry 3 and check it now resolves
        cfg_write(3, 1'b1, 16'hF000, 16'hFFFF);
        run_xfer(16'h0002, 16'hF123, 2'd0, 1'b1, 1'b0, 0);
        run_xfer(16'h0002, 16'h0FFF, 2'd0, 1'b1, 1'b0, 0);

        // Random mix
        for (int t = 0; t < 150; t++) begin
            logic [15:0] g, a;
            int sel, kind;
            g = 16'($urandom);
            if (g == 0) g = 16'h0040;
            sel = int'($urandom % 4);
            a = (sel == 0) ? 16'(16'h1000 + ($urandom % 16'h2000)) :
                (sel == 1) ? 16'h8000 : (sel == 2) ? 16'h7FFF : 16'($urandom);
            kind = int'($urandom % 8);
            if (kind == 0)      run_xfer(g, a, 2'($urandom), 1'b0, 1'b0, 0);
            else if (kind == 1) run_xfer(g, a, 2'($urandom), 1'b1, 1'b1, 0);
            else                run_xfer(g, a, 2'($urandom), kind[0], !kind[0], 3);
            if ($urandom % 3 == 0) idle_cycles(int'($urandom % 3) + 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule